// File: doc/BRIEF.md
# Status Byte and Service Request Generator

This block builds the 8-bit status byte of an instrument control interface and decides when the instrument asks its controller for service. Five sources feed the byte: a non-empty flag taken from the error count, the questionable and operation summary inputs, a message-available flag from a built-in 16-byte outgoing message FIFO, and a summary of a standard event register that the block holds, together with that register's enable mask.

A service request enable mask chooses which status byte bits contribute to the master summary. A rising edge of the master summary latches a request flag, which drives the service request output. The status byte can be read in two ways. A query read shows the master summary in bit 6 and has no side effect. A serial-poll read shows the latched request flag in bit 6 and clears that flag. The message formatter writes bytes into the FIFO, and the bus side drains it. The physical bus layer is outside this block.

Top module: `srq_status_unit`

## Requirements
- R1: The query byte carries: bit 2 = error count non-zero, bit 3 = questionable summary, bit 4 = message available, bit 5 = event summary, bit 6 = master summary, bit 7 = operation summary. Bits 0 and 1 read 0.
- R2: Bit 4 of both read bytes is 1 exactly while the message FIFO holds at least one byte.
- R3: The event summary (bit 5) is the OR of the bitwise AND of the event register and the event enable mask. The mask is written through a write strobe and reads back unchanged.
- R4: The master summary is the OR of the status bits AND the service enable mask. Enable bit 6 is ignored. The service enable mask reads back as written.
- R5: The request flag `srq` goes to 1 on the clock edge after a cycle in which the master summary is 1 and was 0 in the cycle before. It then stays at 1 until a serial poll clears it.
- R6: The poll byte equals the query byte except that bit 6 holds the request flag. A poll strobe clears the flag at the next edge, unless the master summary rises in that same cycle. A query has no side effect.
- R7: Event input bits are latched at the next edge: bit 0 = operation complete, bit 2 = query error, bit 3 = device error, bit 4 = execution error, bit 5 = command error, bit 7 = power-up. Input bits 1 and 6 are ignored.
- R8: A read strobe on the event register clears it at the next edge. Events set in the same cycle as the read are kept.
- R9: The FIFO holds 16 bytes. `msg_full` is 1 at 16 bytes, and a write while full is dropped, even when a read happens in the same cycle.
- R10: Bytes leave the FIFO in write order. The head byte is shown on `msg_rd_data`, and a read strobe on an empty FIFO has no effect.
- R11: After reset the event register holds only the power-up bit (0x80). Both masks are 0, the FIFO is empty and `srq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_count | input | ERR_W | Number of entries in the error queue |
| ques_sum | input | 1 | Questionable status summary |
| oper_sum | input | 1 | Operation status summary |
| msg_wr_en | input | 1 | Push a byte into the message FIFO |
| msg_wr_data | input | DATA_W | Byte to push |
| msg_rd_en | input | 1 | Pop the head byte |
| msg_rd_data | output | DATA_W | Head byte of the FIFO |
| msg_full | output | 1 | FIFO holds DEPTH bytes |
| evt_set | input | 8 | Per-bit event set pulses |
| evt_rd | input | 1 | Read-and-clear strobe for the event register |
| evt_q | output | 8 | Event register contents |
| evt_mask_we | input | 1 | Write strobe for the event enable mask |
| evt_mask_wd | input | 8 | New event enable mask |
| evt_mask_q | output | 8 | Event enable mask |
| srv_mask_we | input | 1 | Write strobe for the service enable mask |
| srv_mask_wd | input | 8 | New service enable mask |
| srv_mask_q | output | 8 | Service enable mask |
| poll_rd | input | 1 | Serial-poll read strobe |
| query_byte | output | 8 | Status byte for a query read |
| poll_byte | output | 8 | Status byte for a serial-poll read |
| srq | output | 1 | Service request |

## Verification
The status bits in `query_byte` and `poll_byte` follow the summary and error inputs in the same cycle. Register writes, event sets, event reads and FIFO pushes and pops show up one edge after the cycle that presents them. The request flag follows a master summary rise by one edge, and a poll clears it one edge after the poll cycle. The bench drives each stimulus for exactly one cycle after a falling edge. It compares every output with a behavioural model just before the next rising edge, and advances the model at that edge, so each result is sampled in the cycle its latency puts it in.

// File: rtl/srq_pkg.sv
// Shared bit positions for the status byte and the standard event register.
package srq_pkg;
    // Status byte bit positions (read by the controller, so fixed).
    localparam int SB_ERR  = 2;
    localparam int SB_QUES = 3;
    localparam int SB_MAV  = 4;
    localparam int SB_ESB  = 5;
    localparam int SB_RQS  = 6;
    localparam int SB_OPER = 7;

    // Standard event register bit positions.
    localparam int EV_DONE      = 0;
    localparam int EV_QUERY_ERR = 2;
    localparam int EV_DEV_ERR   = 3;
    localparam int EV_EXEC_ERR  = 4;
    localparam int EV_CMD_ERR   = 5;
    localparam int EV_POWER_UP  = 7;

    // Bits of the event register that exist.
    localparam logic [7:0] EV_VALID = (8'd1 << EV_DONE) | (8'd1 << EV_QUERY_ERR) |
                                      (8'd1 << EV_DEV_ERR) | (8'd1 << EV_EXEC_ERR) |
                                      (8'd1 << EV_CMD_ERR) | (8'd1 << EV_POWER_UP);
endpackage

// File: rtl/srq_byte_fifo.sv
// Outgoing message FIFO with a show-ahead head byte.
// Assumes: one push and one pop per cycle at most. A push while full is
// dropped even when a pop happens in the same cycle. A pop while empty is ignored.
module srq_byte_fifo #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              full,
    output logic              nonempty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic [CW-1:0]     count;
    logic              do_wr, do_rd;

    // Accept a push only with room, a pop only with data.
    always_comb begin
        full     = (count == CW'(DEPTH));
        nonempty = (count != '0);
        do_wr    = wr_en && !full;
        do_rd    = rd_en && nonempty;
        rd_data  = mem[rd_ptr];
    end

    // Storage array, written at the write pointer.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_data;
    end

    // Pointers and fill count with explicit wrap for any depth.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_rd) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/srq_event_reg.sv
// Standard event register with its enable mask and summary output.
// Assumes: set pulses are sticky until a read, and a read clears the register
// except for bits set in the same cycle. Reset leaves only the power-up bit.
module srq_event_reg
    import srq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] evt_set,
    input  logic       rd_clr,
    input  logic       mask_we,
    input  logic [7:0] mask_wd,
    output logic [7:0] event_q,
    output logic [7:0] mask_q,
    output logic       summary
);
    // Sticky event bits, cleared by a read, restricted to existing bits.
    always_ff @(posedge clk) begin
        if (!rst_n) event_q <= 8'd1 << EV_POWER_UP;
        else        event_q <= (rd_clr ? 8'd0 : event_q) | (evt_set & EV_VALID);
    end

    // Enable mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= mask_wd;
    end

    // Summary of enabled events.
    always_comb summary = |(event_q & mask_q);
endmodule

// File: rtl/srq_request.sv
// Service request logic: enable mask, master summary, request flag, read views.
// Assumes: status_base carries 0 in bit 6. The request flag sets on a rising
// master summary and clears on a poll. A rise in the poll cycle sets it again.
module srq_request
    import srq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] status_base,
    input  logic       mask_we,
    input  logic [7:0] mask_wd,
    output logic [7:0] mask_q,
    input  logic       poll_rd,
    output logic [7:0] query_byte,
    output logic [7:0] poll_byte,
    output logic       srq
);
    localparam logic [7:0] SELF_BIT = 8'd1 << SB_RQS;

    logic mss, mss_prev, rqs;

    // Service enable mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= mask_wd;
    end

    // Master summary, ignoring enable bit 6 so the summary never feeds itself.
    always_comb mss = |(status_base & mask_q & ~SELF_BIT);

    // Previous master summary for edge detection, and the request flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mss_prev <= 1'b0;
            rqs      <= 1'b0;
        end else begin
            mss_prev <= mss;
            rqs      <= (rqs && !poll_rd) || (mss && !mss_prev);
        end
    end

    // The two read views differ only in bit 6.
    always_comb begin
        query_byte         = status_base;
        query_byte[SB_RQS] = mss;
        poll_byte          = status_base;
        poll_byte[SB_RQS]  = rqs;
        srq                = rqs;
    end
endmodule

// File: rtl/srq_status_unit.sv
// Top: assembles the status byte from the error count, the summaries, the
// message FIFO and the event register, and generates the service request.
// Assumes: summary inputs are synchronous to clk. Strobes are single-cycle.
module srq_status_unit
    import srq_pkg::*;
#(
    parameter int ERR_W  = 8,
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ERR_W-1:0]  err_count,
    input  logic              ques_sum,
    input  logic              oper_sum,
    input  logic              msg_wr_en,
    input  logic [DATA_W-1:0] msg_wr_data,
    input  logic              msg_rd_en,
    output logic [DATA_W-1:0] msg_rd_data,
    output logic              msg_full,
    input  logic [7:0]        evt_set,
    input  logic              evt_rd,
    output logic [7:0]        evt_q,
    input  logic              evt_mask_we,
    input  logic [7:0]        evt_mask_wd,
    output logic [7:0]        evt_mask_q,
    input  logic              srv_mask_we,
    input  logic [7:0]        srv_mask_wd,
    output logic [7:0]        srv_mask_q,
    input  logic              poll_rd,
    output logic [7:0]        query_byte,
    output logic [7:0]        poll_byte,
    output logic              srq
);
    logic       mav, esb;
    logic [7:0] status_base;

    srq_byte_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (msg_wr_en),
        .wr_data  (msg_wr_data),
        .rd_en    (msg_rd_en),
        .rd_data  (msg_rd_data),
        .full     (msg_full),
        .nonempty (mav)
    );

    srq_event_reg u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_set (evt_set),
        .rd_clr  (evt_rd),
        .mask_we (evt_mask_we),
        .mask_wd (evt_mask_wd),
        .event_q (evt_q),
        .mask_q  (evt_mask_q),
        .summary (esb)
    );

    // Place each source at its status byte position. Bits 0, 1 and 6 stay 0 here.
    always_comb begin
        status_base          = '0;
        status_base[SB_ERR]  = (err_count != '0);
        status_base[SB_QUES] = ques_sum;
        status_base[SB_MAV]  = mav;
        status_base[SB_ESB]  = esb;
        status_base[SB_OPER] = oper_sum;
    end

    srq_request u_req (
        .clk         (clk),
        .rst_n       (rst_n),
        .status_base (status_base),
        .mask_we     (srv_mask_we),
        .mask_wd     (srv_mask_wd),
        .mask_q      (srv_mask_q),
        .poll_rd     (poll_rd),
        .query_byte  (query_byte),
        .poll_byte   (poll_byte),
        .srq         (srq)
    );
endmodule

// File: rtl/srq_status_chk.sv
// Assertion checker for srq_status_unit, attached by bind.
module srq_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       msg_full,
    input logic       msg_rd_en,
    input logic [7:0] evt_q,
    input logic       poll_rd,
    input logic [7:0] query_byte,
    input logic [7:0] poll_byte,
    input logic       srq
);
    AST_FULL_IMPLIES_MAV: assert property (@(posedge clk) disable iff (!rst_n)
        msg_full |-> query_byte[4]); // R2
    AST_RISE_SETS_SRQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(query_byte[6]) |=> srq); // R5
    AST_SRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (srq && !poll_rd) |=> srq); // R5
    AST_POLL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_rd && !query_byte[6]) |=> !srq); // R6
    AST_POLL_OTHER_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_byte[5:0] == query_byte[5:0]) && (poll_byte[7] == query_byte[7])); // R6
    AST_FULL_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_full && !msg_rd_en) |=> msg_full); // R9
    AST_NO_PHANTOM_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_q[1] == 1'b0) && (evt_q[6] == 1'b0)); // R7
endmodule

bind srq_status_unit srq_status_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .msg_full   (msg_full),
    .msg_rd_en  (msg_rd_en),
    .evt_q      (evt_q),
    .poll_rd    (poll_rd),
    .query_byte (query_byte),
    .poll_byte  (poll_byte),
    .srq        (srq)
);

// File: tb/tb_srq_status_unit.sv
// Bench: behavioural reference model compared with every output once per clock.
module tb_srq_status_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] err_count = '0;
    logic       ques_sum = 1'b0, oper_sum = 1'b0;
    logic       msg_wr_en = 1'b0, msg_rd_en = 1'b0;
    logic [7:0] msg_wr_data = '0;
    logic [7:0] msg_rd_data;
    logic       msg_full;
    logic [7:0] evt_set = '0;
    logic       evt_rd = 1'b0;
    logic [7:0] evt_q;
    logic       evt_mask_we = 1'b0;
    logic [7:0] evt_mask_wd = '0;
    logic [7:0] evt_mask_q;
    logic       srv_mask_we = 1'b0;
    logic [7:0] srv_mask_wd = '0;
    logic [7:0] srv_mask_q;
    logic       poll_rd = 1'b0;
    logic [7:0] query_byte, poll_byte;
    logic       srq;

    always #10 clk = ~clk; // 50 MHz

    srq_status_unit dut (.*);

    int checks = 0, fails = 0;
    bit done = 1'b0;

    // Reference state.
    int   q[$];
    int   m_evt = 8'h80, m_emask = 0, m_smask = 0;
    bit   m_rqs = 1'b0, m_mss_prev = 1'b0;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Compare outputs to the model, advance one clock, release strobes.
    task automatic tick();
        int base, mss, qb;
        #1;
        base = ((err_count != 0) << 2) | (ques_sum << 3) | ((q.size() > 0) << 4) |
               (((m_evt & m_emask) != 0) << 5) | (oper_sum << 7);
        mss  = ((base & m_smask & 8'hBF) != 0);
        qb   = base | (mss << 6);
        chk("R1", query_byte & 8'h8F, qb & 8'h8F);
        chk("R2", query_byte[4], (q.size() > 0));
        chk("R3", query_byte[5], (base >> 5) & 1);
        chk("R4", query_byte[6], mss);
        chk("R5", srq, m_rqs);
        chk("R6", poll_byte, base | (m_rqs << 6));
        chk("R7 R8", evt_q, m_evt);
        chk("R3", evt_mask_q, m_emask);
        chk("R4", srv_mask_q, m_smask);
        chk("R9", msg_full, (q.size() == 16));
        if (q.size() > 0) chk("R10", msg_rd_data, q[0]);
        // Model update for this edge.
        begin
            bit pushok;
            pushok = msg_wr_en && (q.size() < 16);
            if (msg_rd_en && q.size() > 0) void'(q.pop_front());
            if (pushok) q.push_back(msg_wr_data);
        end
        m_evt = (evt_rd ? 0 : m_evt) | (evt_set & 8'hBD);
        if (evt_mask_we) m_emask = evt_mask_wd;
        if (srv_mask_we) m_smask = srv_mask_wd;
        m_rqs = (m_rqs && !poll_rd) || (mss != 0 && !m_mss_prev);
        m_mss_prev = (mss != 0);
        @(posedge clk);
        @(negedge clk);
        msg_wr_en = 0; msg_rd_en = 0; evt_set = 0; evt_rd = 0;
        evt_mask_we = 0; srv_mask_we = 0; poll_rd = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R11: reset state
        chk("R11", evt_q, 8'h80);
        chk("R11", srq, 0);
        chk("R11", query_byte, 8'h00);
        chk("R11", msg_full, 0);
        repeat (2) tick();
        // R8: read clears, including power-up bit
        evt_rd = 1; tick(); tick();
        chk("R8", evt_q, 8'h00);
        // R7: all inputs pulsed, bits 1 and 6 ignored
        evt_set = 8'hFF; tick(); tick();
        chk("R7", evt_q, 8'hBD);
        // R8: set in read cycle survives
        evt_rd = 1; evt_set = 8'h04; tick(); tick();
        chk("R8", evt_q, 8'h04);
        // R3: enable command error, set it
        evt_mask_we = 1; evt_mask_wd = 8'h20; tick();
        evt_set = 8'h20; tick(); tick();
        chk("R3", query_byte[5], 1);
        // R4/R5: enable event summary for service, rise sets srq
        srv_mask_we = 1; srv_mask_wd = 8'h20; tick(); tick();
        chk("R5", srq, 1);
        // R6: query is side-effect free, poll clears and no re-set while high
        repeat (2) tick();
        poll_rd = 1; tick(); tick();
        chk("R6", srq, 0);
        chk("R6", query_byte[6], 1);
        // Drop and raise summary with poll in the rise cycle
        evt_rd = 1; tick(); tick();
        evt_set = 8'h20; tick();
        poll_rd = 1; tick(); tick();
        chk("R6", srq, 1);
        poll_rd = 1; tick();
        // R4: enable bit 6 alone has no effect
        srv_mask_we = 1; srv_mask_wd = 8'h40; tick();
        err_count = 8'd3; ques_sum = 1; oper_sum = 1; tick(); tick();
        chk("R4", query_byte[6], 0);
        // R1: sources toggled with enables on bits 2,3,7
        srv_mask_we = 1; srv_mask_wd = 8'h8C; tick();
        ques_sum = 0; tick(); oper_sum = 0; tick(); err_count = 0; tick();
        oper_sum = 1; tick(); tick(); poll_rd = 1; tick(); oper_sum = 0; tick();
        // R9/R10: fill past depth, then drain and over-read
        for (int i = 0; i < 17; i++) begin
            msg_wr_en = 1; msg_wr_data = 8'(i * 7 + 3); tick();
        end
        chk("R9", msg_full, 1);
        msg_wr_en = 1; msg_wr_data = 8'hEE; msg_rd_en = 1; tick();
        chk("R9", msg_full, 0);
        for (int i = 0; i < 17; i++) begin
            msg_rd_en = 1; tick();
        end
        chk("R2", query_byte[4], 0);
        msg_wr_en = 1; msg_wr_data = 8'h5A; msg_rd_en = 1; tick();
        chk("R10", msg_rd_data, 8'h5A);
        msg_wr_en = 1; msg_wr_data = 8'hA5; msg_rd_en = 1; tick();
        repeat (3) tick();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule